// File: doc/BRIEF.md
# Code Read Protection Gate

This block is the policy point for access to on-chip flash from outside the chip. After reset it takes one 32-bit protection word from boot and turns it into one of four protection levels, then holds that level until the next reset. From that level it decides three things: whether the debug port may open, whether the chip may enter in-system programming (ISP), and whether each ISP command is granted or denied. Each ISP command is described by a command class and a range of flash sectors.

Only three specific word values select a protection level. Every other word leaves the chip unprotected. A strap input marks reduced-feature parts; on those parts any recognised protection word acts as level 2. ISP entry comes from a boot pin that is sampled in the same cycle as the protection word. At level 3 that pin is ignored, and ISP can only be entered when the running application asks for it.

Each command gets exactly one answer: a grant pulse or a deny pulse, one cycle wide. Every deny also sets a sticky error flag. Software clears that flag by writing 1 to `err_clr_i`.

Top module: `crp_gate`

## Requirements
- R1: From reset until the protection word has been latched, `dbg_en_o`, `isp_en_o` and `err_o` are 0, and every command issued in that time is denied.
- R2: The level is decoded from the latched word. 32'h1A2B_3C4D selects level 1, 32'h5E6F_7081 selects level 2, 32'h92A3_B4C5 selects level 3, and any other value selects no protection. `dbg_en_o` equals `dbg_req_i` only when the level is none; at every other level it is 0.
- R3: When `reduced_part_i` is 1 at latch time, a level-1 or level-3 word acts as level 2: the pin enters ISP, the debug port stays closed, and level-2 command rules apply. A word that is not recognised still means no protection.
- R4: `isp_pin_i` is sampled only in the latch cycle. At levels none, 1 and 2, a 1 there sets `isp_en_o`. A change on the pin after latch has no effect.
- R5: At level 3 the pin does not set `isp_en_o`. After latch, a cycle with `app_isp_req_i` high sets `isp_en_o` at any level. Once set, `isp_en_o` stays set until reset.
- R6: While `isp_en_o` is 0, every command is denied.
- R7: At level 1 the following are granted: class 0 (identify), class 1 (RAM write), class 6 (go), and class 2 (sector erase) or class 3 (program) when the low sector is not 0. Class 4 (full erase), class 5 (read) and any erase or program that covers sector 0 are denied.
- R8: At levels 2 and 3 the following are granted: classes 0 and 1, and class 4 (full erase). Class 3 (program) is granted only after a full erase has been granted since reset. Classes 2, 5 and 6 are denied.
- R9: At level none every command is granted, except two cases that are denied at all levels: class 7 (reserved), and a sector range whose low index is above its high index.
- R10: A command presented with `cmd_valid_i` at a clock edge gives exactly one of `cmd_grant_o` or `cmd_deny_o` for the following cycle. With no command, neither output is high.
- R11: A deny sets `err_o`, and it stays set until a cycle with `err_clr_i` high. If a deny and a clear arrive in the same cycle, the flag stays set.
- R12: The level and the pin sample are taken once, on the first cycle of `boot_valid_i` after reset. Later strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_valid_i | input | 1 | Boot word is valid in this cycle |
| boot_word_i | input | 32 | Protection word read at boot |
| reduced_part_i | input | 1 | Strap that marks a reduced-feature part |
| isp_pin_i | input | 1 | ISP boot pin, sampled at latch |
| app_isp_req_i | input | 1 | Application requests ISP entry |
| dbg_req_i | input | 1 | Debug port access request |
| cmd_valid_i | input | 1 | ISP command present |
| cmd_class_i | input | 3 | Command class |
| cmd_sect_lo_i | input | 4 | Lowest sector the command touches |
| cmd_sect_hi_i | input | 4 | Highest sector the command touches |
| err_clr_i | input | 1 | Write-1 clear of the error flag |
| dbg_en_o | output | 1 | Debug port enable |
| isp_en_o | output | 1 | ISP entry allowed |
| cmd_grant_o | output | 1 | One-cycle grant pulse |
| cmd_deny_o | output | 1 | One-cycle deny pulse |
| err_o | output | 1 | Sticky error flag |

## Verification
The assertions assume that reset is held long enough to clear all state and that `boot_valid_i` is driven only after reset is released. They also assume that each command is a single-cycle `cmd_valid_i` with its class and sector fields stable around the capture edge. The bench drives every input at the falling clock edge and presents one command at a time, then leaves an idle cycle before the next. This lets every response pulse and its trailing quiet cycle be seen on their own. Each scenario starts from a fresh reset and a single boot strobe, except the scenario that deliberately sends a second strobe to check R12.

// File: rtl/crp_pkg.sv
package crp_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_1    = 2'd1,
    LVL_2    = 2'd2,
    LVL_3    = 2'd3
  } crp_lvl_e;

  typedef enum logic [2:0] {
    CMD_ID        = 3'd0,
    CMD_RAM_WR    = 3'd1,
    CMD_ERASE_SEC = 3'd2,
    CMD_PROG      = 3'd3,
    CMD_ERASE_ALL = 3'd4,
    CMD_READ      = 3'd5,
    CMD_GO        = 3'd6,
    CMD_RSVD      = 3'd7
  } crp_cmd_e;
endpackage

// File: rtl/crp_level_latch.sv
module crp_level_latch
  import crp_pkg::*;
#(
  parameter int unsigned          WORD_W   = 32,
  parameter logic [WORD_W-1:0]    MAGIC_L1 = 32'h1A2B_3C4D,
  parameter logic [WORD_W-1:0]    MAGIC_L2 = 32'h5E6F_7081,
  parameter logic [WORD_W-1:0]    MAGIC_L3 = 32'h92A3_B4C5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boot_valid_i,
  input  logic [WORD_W-1:0] boot_word_i,
  input  logic              reduced_part_i,
  input  logic              isp_pin_i,
  input  logic              app_isp_req_i,
  output logic              done_o,
  output crp_lvl_e          lvl_o,
  output logic              isp_en_o
);
  crp_lvl_e raw_lvl, eff_lvl;

  always_comb begin
    if (boot_word_i == MAGIC_L1)      raw_lvl = LVL_1;
    else if (boot_word_i == MAGIC_L2) raw_lvl = LVL_2;
    else if (boot_word_i == MAGIC_L3) raw_lvl = LVL_3;
    else                              raw_lvl = LVL_NONE;
    // reduced parts only implement level 2
    eff_lvl = (reduced_part_i && raw_lvl != LVL_NONE) ? LVL_2 : raw_lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      lvl_o    <= LVL_NONE;
      isp_en_o <= 1'b0;
    end else if (!done_o) begin
      if (boot_valid_i) begin
        done_o   <= 1'b1;
        lvl_o    <= eff_lvl;
        isp_en_o <= isp_pin_i && (eff_lvl != LVL_3);
      end
    end else if (app_isp_req_i) begin
      isp_en_o <= 1'b1;
    end
  end
endmodule

// File: rtl/crp_cmd_policy.sv
module crp_cmd_policy
  import crp_pkg::*;
#(
  parameter int unsigned SECT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  crp_lvl_e          lvl_i,
  input  logic              isp_en_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_class_i,
  input  logic [SECT_W-1:0] sect_lo_i,
  input  logic [SECT_W-1:0] sect_hi_i,
  input  logic              err_clr_i,
  output logic              grant_o,
  output logic              deny_o,
  output logic              err_o
);
  crp_cmd_e cls;
  logic     allow;
  logic     erased_q;
  logic     touches_s0;

  assign cls        = crp_cmd_e'(cmd_class_i);
  assign touches_s0 = (sect_lo_i == '0);

  always_comb begin
    allow = 1'b0;
    if (done_i && isp_en_i && (sect_lo_i <= sect_hi_i) && cls != CMD_RSVD) begin
      case (lvl_i)
        LVL_NONE: allow = 1'b1;
        LVL_1: begin
          case (cls)
            CMD_ID, CMD_RAM_WR, CMD_GO: allow = 1'b1;
            CMD_ERASE_SEC, CMD_PROG:    allow = !touches_s0;
            default:                    allow = 1'b0;
          endcase
        end
        default: begin
          case (cls)
            CMD_ID, CMD_RAM_WR, CMD_ERASE_ALL: allow = 1'b1;
            CMD_PROG:                          allow = erased_q;
            default:                           allow = 1'b0;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o  <= 1'b0;
      deny_o   <= 1'b0;
      err_o    <= 1'b0;
      erased_q <= 1'b0;
    end else begin
      grant_o <= cmd_valid_i && allow;
      deny_o  <= cmd_valid_i && !allow;
      if (cmd_valid_i && allow && cls == CMD_ERASE_ALL) erased_q <= 1'b1;
      // set wins over clear
      if (cmd_valid_i && !allow) err_o <= 1'b1;
      else if (err_clr_i)        err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/crp_gate.sv
module crp_gate
  import crp_pkg::*;
#(
  parameter int unsigned       WORD_W   = 32,
  parameter int unsigned       SECT_W   = 4,
  parameter logic [WORD_W-1:0] MAGIC_L1 = 32'h1A2B_3C4D,
  parameter logic [WORD_W-1:0] MAGIC_L2 = 32'h5E6F_7081,
  parameter logic [WORD_W-1:0] MAGIC_L3 = 32'h92A3_B4C5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boot_valid_i,
  input  logic [WORD_W-1:0] boot_word_i,
  input  logic              reduced_part_i,
  input  logic              isp_pin_i,
  input  logic              app_isp_req_i,
  input  logic              dbg_req_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_class_i,
  input  logic [SECT_W-1:0] cmd_sect_lo_i,
  input  logic [SECT_W-1:0] cmd_sect_hi_i,
  input  logic              err_clr_i,
  output logic              dbg_en_o,
  output logic              isp_en_o,
  output logic              cmd_grant_o,
  output logic              cmd_deny_o,
  output logic              err_o
);
  logic     lvl_done;
  crp_lvl_e lvl_q;

  crp_level_latch #(
    .WORD_W(WORD_W), .MAGIC_L1(MAGIC_L1), .MAGIC_L2(MAGIC_L2), .MAGIC_L3(MAGIC_L3)
  ) u_latch (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .boot_valid_i   (boot_valid_i),
    .boot_word_i    (boot_word_i),
    .reduced_part_i (reduced_part_i),
    .isp_pin_i      (isp_pin_i),
    .app_isp_req_i  (app_isp_req_i),
    .done_o         (lvl_done),
    .lvl_o          (lvl_q),
    .isp_en_o       (isp_en_o)
  );

  crp_cmd_policy #(.SECT_W(SECT_W)) u_policy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (lvl_done),
    .lvl_i       (lvl_q),
    .isp_en_i    (isp_en_o),
    .cmd_valid_i (cmd_valid_i),
    .cmd_class_i (cmd_class_i),
    .sect_lo_i   (cmd_sect_lo_i),
    .sect_hi_i   (cmd_sect_hi_i),
    .err_clr_i   (err_clr_i),
    .grant_o     (cmd_grant_o),
    .deny_o      (cmd_deny_o),
    .err_o       (err_o)
  );

  // closed until latched, so no open window after reset
  assign dbg_en_o = lvl_done && (lvl_q == LVL_NONE) && dbg_req_i;
endmodule

// File: rtl/crp_gate_chk.sv
module crp_gate_chk
  import crp_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     done_i,
  input crp_lvl_e lvl_i,
  input logic     dbg_en_i,
  input logic     isp_en_i,
  input logic     cmd_valid_i,
  input logic     grant_i,
  input logic     deny_i,
  input logic     err_i,
  input logic     err_clr_i
);
  p_dbg_closed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> !dbg_en_i);
  p_dbg_only_none_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_en_i |-> lvl_i == LVL_NONE);
  p_isp_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isp_en_i |=> isp_en_i);
  p_one_outcome_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> (grant_i ^ deny_i));
  p_quiet_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !(grant_i || deny_i));
  p_deny_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_i |-> err_i);
  p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !err_clr_i) |=> err_i);
  p_lvl_frozen_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> ($stable(lvl_i) && done_i));
endmodule

bind crp_gate crp_gate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_i      (lvl_done),
  .lvl_i       (lvl_q),
  .dbg_en_i    (dbg_en_o),
  .isp_en_i    (isp_en_o),
  .cmd_valid_i (cmd_valid_i),
  .grant_i     (cmd_grant_o),
  .deny_i      (cmd_deny_o),
  .err_i       (err_o),
  .err_clr_i   (err_clr_i)
);

// File: tb/crp_gate_bench.sv
`timescale 1ns/1ps
module crp_gate_bench;
  localparam logic [31:0] M1 = 32'h1A2B_3C4D;
  localparam logic [31:0] M2 = 32'h5E6F_7081;
  localparam logic [31:0] M3 = 32'h92A3_B4C5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic boot_valid = 0, reduced = 0, pin = 0, app_req = 0, dbg_req = 1;
  logic [31:0] word = '0;
  logic cmd_valid = 0, err_clr = 0;
  logic [2:0] cls = '0;
  logic [3:0] slo = '0, shi = '0;
  logic dbg_en, isp_en, grant, deny, err;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  crp_gate u_crp_gate (
    .clk_i(clk), .rst_ni(rst_n), .boot_valid_i(boot_valid), .boot_word_i(word),
    .reduced_part_i(reduced), .isp_pin_i(pin), .app_isp_req_i(app_req),
    .dbg_req_i(dbg_req), .cmd_valid_i(cmd_valid), .cmd_class_i(cls),
    .cmd_sect_lo_i(slo), .cmd_sect_hi_i(shi), .err_clr_i(err_clr),
    .dbg_en_o(dbg_en), .isp_en_o(isp_en), .cmd_grant_o(grant),
    .cmd_deny_o(deny), .err_o(err)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; boot_valid = 0; cmd_valid = 0; app_req = 0; err_clr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic boot(input logic [31:0] w, input logic p, input logic red);
    do_reset();
    @(negedge clk);
    word = w; pin = p; reduced = red; boot_valid = 1;
    @(negedge clk);
    boot_valid = 0; word = '0; pin = 0; reduced = 0;
  endtask

  task automatic issue(input logic [2:0] c, input logic [3:0] lo, input logic [3:0] hi,
                       input logic exp, input string req);
    @(negedge clk);
    cmd_valid = 1; cls = c; slo = lo; shi = hi;
    @(negedge clk);
    cmd_valid = 0;
    chk(req, grant, exp);
    chk(req, deny, !exp);
    if (!exp) chk({req, " R11 err set"}, err, 1'b1);
    @(negedge clk);
    chk("R10 pulse ends", grant | deny, 1'b0);
  endtask

  task automatic t_reset_r1();
    do_reset();
    @(negedge clk);
    chk("R1 dbg closed", dbg_en, 1'b0);
    chk("R1 isp off", isp_en, 1'b0);
    chk("R1 err clear", err, 1'b0);
    issue(3'd0, 4'd1, 4'd1, 1'b0, "R1 cmd before latch");
  endtask

  task automatic t_none_r9();
    boot(32'h0, 1'b1, 1'b0);
    chk("R2 dbg open at none", dbg_en, 1'b1);
    dbg_req = 0; #1;
    chk("R2 dbg follows req", dbg_en, 1'b0);
    dbg_req = 1;
    chk("R4 pin enters isp", isp_en, 1'b1);
    issue(3'd5, 4'd0, 4'd15, 1'b1, "R9 read at none");
    issue(3'd2, 4'd0, 4'd0, 1'b1, "R9 erase s0 at none");
    issue(3'd3, 4'd5, 4'd2, 1'b0, "R9 lo>hi denied");
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    chk("R11 clear", err, 1'b0);
    issue(3'd7, 4'd1, 4'd1, 1'b0, "R9 reserved class");
    // deny and clear in the same cycle
    @(negedge clk); cmd_valid = 1; cls = 3'd7; err_clr = 1;
    @(negedge clk); cmd_valid = 0; err_clr = 0;
    chk("R11 set wins deny", deny, 1'b1);
    chk("R11 set wins err", err, 1'b1);
  endtask

  task automatic t_l1_r7();
    boot(M1, 1'b1, 1'b0);
    chk("R2 dbg closed at L1", dbg_en, 1'b0);
    issue(3'd2, 4'd1, 4'd3, 1'b1, "R7 erase 1..3");
    issue(3'd2, 4'd0, 4'd2, 1'b0, "R7 erase covers s0");
    issue(3'd3, 4'd0, 4'd0, 1'b0, "R7 prog s0");
    issue(3'd3, 4'd4, 4'd4, 1'b1, "R7 prog s4");
    issue(3'd5, 4'd1, 4'd1, 1'b0, "R7 read");
    issue(3'd4, 4'd0, 4'd15, 1'b0, "R7 full erase");
    issue(3'd6, 4'd0, 4'd0, 1'b1, "R7 go");
    @(negedge clk); word = 32'h0; boot_valid = 1;
    @(negedge clk); boot_valid = 0;
    chk("R12 second strobe ignored", dbg_en, 1'b0);
  endtask

  task automatic t_l2_r8();
    boot(M2, 1'b1, 1'b0);
    chk("R2 dbg closed at L2", dbg_en, 1'b0);
    chk("R4 pin at L2", isp_en, 1'b1);
    issue(3'd2, 4'd2, 4'd2, 1'b0, "R8 sector erase");
    issue(3'd3, 4'd1, 4'd1, 1'b0, "R8 prog before erase");
    issue(3'd4, 4'd0, 4'd15, 1'b1, "R8 full erase");
    issue(3'd3, 4'd0, 4'd0, 1'b1, "R8 prog after erase");
    issue(3'd6, 4'd0, 4'd0, 1'b0, "R8 go");
  endtask

  task automatic t_l3_r5();
    boot(M3, 1'b1, 1'b0);
    chk("R5 pin ignored at L3", isp_en, 1'b0);
    chk("R2 dbg closed at L3", dbg_en, 1'b0);
    issue(3'd0, 4'd1, 4'd1, 1'b0, "R6 no isp entry");
    @(negedge clk); app_req = 1;
    @(negedge clk); app_req = 0;
    chk("R5 app request", isp_en, 1'b1);
    issue(3'd4, 4'd0, 4'd15, 1'b1, "R8 full erase at L3");
    issue(3'd5, 4'd0, 4'd0, 1'b0, "R8 read at L3");
  endtask

  task automatic t_reduced_r3();
    boot(M1, 1'b1, 1'b1);
    chk("R3 L1 word pin", isp_en, 1'b1);
    issue(3'd2, 4'd1, 4'd1, 1'b0, "R3 L1 word acts L2");
    boot(M3, 1'b1, 1'b1);
    chk("R3 L3 word pin works", isp_en, 1'b1);
    chk("R3 L3 word dbg closed", dbg_en, 1'b0);
    boot(32'hDEAD_0001, 1'b0, 1'b1);
    chk("R3 unknown word none", dbg_en, 1'b1);
  endtask

  task automatic t_nopin_r4();
    boot(32'h0, 1'b0, 1'b0);
    chk("R4 pin low", isp_en, 1'b0);
    issue(3'd0, 4'd1, 4'd1, 1'b0, "R6 denied without isp");
    @(negedge clk); pin = 1;
    @(negedge clk);
    chk("R4 late pin ignored", isp_en, 1'b0);
    pin = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_r1();
    t_none_r9();
    t_l1_r7();
    t_l2_r8();
    t_l3_r5();
    t_reduced_r3();
    t_nopin_r4();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule